// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a 16-bit instruction fetch port and a consumer that takes one instruction byte at a time. While the buffer has room and no operand access is waiting, it requests aligned word fetches. It loads the returned bytes in address order and offers them to the consumer from the head of the buffer. The fetch address is formed from a 16-bit segment value and a 16-bit offset.

When control transfers, the block drops everything it holds. It reloads its segment and offset from the branch target and starts fetching again. A word that was already in flight when the transfer happened is allowed to finish on the bus, but its data is thrown away.

A 2-bit status output reports, one clock later, what happened at the head of the buffer on the previous clock. The possible events are: nothing taken, the first byte of an instruction taken, a later byte of an instruction taken, or the buffer reinitialised by a transfer of control.

Top module: `fbq_top`

## Requirements
- R1: The buffer holds at most 6 bytes. With 5 or 6 bytes stored, no new fetch request is raised.
- R2: A fetch request rises only after a clock at which all of these held: no request outstanding, at least two byte slots free, `opnd_req` low and `redirect` low. Once raised, `fetch_req` stays high with `fetch_addr` unchanged until the clock at which `fetch_ack` is high.
- R3: A returned word carries the byte at the even address in `fetch_data[7:0]` and the next byte in `fetch_data[15:8]`. Bytes reach `byte_data` in strictly ascending address order, lower byte first.
- R4: `opnd_grant` is high exactly when `opnd_req` is high and no fetch is outstanding. A fetch already in flight therefore completes before the operand access is granted.
- R5: On a clock with `redirect` high, all stored bytes are discarded: `byte_valid` is low on the next cycle. The next fetch uses the new target.
- R6: The fetch address is (segment × 16 + offset) modulo 2^20 with bit 0 cleared. After each fetch is issued the offset advances by 2, or by 1 if it was odd. The offset wraps within 16 bits.
- R7: `qstat` is a registered code for the previous clock. The codes are 2'b10 after a redirect, 2'b01 after a byte was taken with `byte_first` high, 2'b11 after a byte was taken with `byte_first` low, and 2'b00 otherwise. A redirect takes precedence over a take.
- R8: While the buffer is empty, `byte_valid` is low and `byte_take` has no effect. The consumer stalls until a fetched byte arrives.
- R9: When the target offset is odd, only the upper byte of the first returned word is loaded.
- R10: A word acknowledged for a request that was outstanding when a redirect occurred loads no byte. The first byte seen after the redirect comes from the new target.
- R11: During and right after reset the outputs are: `fetch_req` low, `byte_valid` low, `qstat` 2'b00. The first fetch after reset is at physical address 20'hFFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect | input | 1 | Transfer of control; load the new target and flush |
| target_seg | input | 16 | Segment value of the branch target |
| target_off | input | 16 | Offset of the branch target |
| fetch_req | output | 1 | Word fetch request, held until acknowledged |
| fetch_addr | output | 20 | Even physical address of the requested word |
| fetch_ack | input | 1 | Fetch complete; `fetch_data` is valid in the same cycle |
| fetch_data | input | 16 | Returned word, lower address byte in bits 7:0 |
| opnd_req | input | 1 | Operand memory access wanted by the execution side |
| opnd_grant | output | 1 | Operand access may use the bus now |
| byte_take | input | 1 | Consumer takes the head byte |
| byte_first | input | 1 | The byte being taken starts an instruction |
| byte_valid | output | 1 | Head byte is present |
| byte_data | output | 8 | Head byte |
| qstat | output | 2 | Buffer status code for the previous clock |

## Verification
Some behaviours are checked by assertions on every clock:
- the fill level never exceeds capacity, and a two-byte load always has room;
- a request holds with a steady, even address until acknowledged, and rises only after a clock with room and no operand request;
- a redirect yields the flush code and an empty head on the next cycle;
- an empty buffer stays empty without a returned word;
- a take shows a taken code on the next cycle.

Other behaviours only the bench scenarios can show, because they need a model of the memory contents. These are: the exact byte stream after odd targets, discarding a word that returns after a redirect, the offset advancing from segment to segment, and the choice between the first-byte and later-byte codes.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'b00,
      QS_FIRST = 2'b01,
      QS_FLUSH = 2'b10,
      QS_NEXT  = 2'b11
   } qstat_e;

endpackage

// File: rtl/fbq_phys.sv
module fbq_phys #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] phys
);
   localparam int SW = SEG_W + SHIFT;

   logic [SW-1:0] seg_sh;

   assign seg_sh = {seg, {SHIFT{1'b0}}};
   assign phys   = ADDR_W'(seg_sh) + ADDR_W'(off);

endmodule

// File: rtl/fbq_store.sv
module fbq_store #(
   parameter int DEPTH  = 6,
   parameter int BYTE_W = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        push_n,
   input  logic [BYTE_W-1:0] in_b0,
   input  logic [BYTE_W-1:0] in_b1,
   input  logic              pop,
   output logic [CW-1:0]     fill,
   output logic [BYTE_W-1:0] head
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
   localparam logic [PW-1:0] LAST2  = PW'(DEPTH - 2);
   localparam logic [CW-1:0] CAP    = CW'(DEPTH);
   localparam logic [CW-1:0] CAP_M2 = CW'(DEPTH - 2);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wp, rp;
   logic [PW-1:0]     wp_1, wp_2, rp_1;
   logic [CW-1:0]     cnt;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_1 = wp + PW'(1);
         assign wp_2 = wp + PW'(2);
         assign rp_1 = rp + PW'(1);
      end else begin : g_wrap_cmp
         assign wp_1 = (wp == LAST) ? '0 : wp + PW'(1);
         assign wp_2 = (wp >= LAST2) ? wp + PW'(2) - PW'(DEPTH) : wp + PW'(2);
         assign rp_1 = (rp == LAST) ? '0 : rp + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!flush && push_n != 2'd0) begin
         mem[wp] <= in_b0;
         if (push_n == 2'd2)
            mem[wp_1] <= in_b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_n == 2'd1)
            wp <= wp_1;
         else if (push_n == 2'd2)
            wp <= wp_2;
         if (pop)
            rp <= rp_1;
         cnt <= cnt + CW'(push_n) - CW'(pop);
      end
   end

   assign fill = cnt;
   assign head = mem[rp];

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CAP);

   // R1
   pair_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_n == 2'd2 && !flush) |-> (cnt <= CAP_M2 + CW'(pop)));

endmodule

// File: rtl/fbq_ctrl.sv
module fbq_ctrl
   import fbq_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20,
   parameter logic [SEG_W-1:0] BOOT_SEG = '1,
   parameter logic [OFF_W-1:0] BOOT_OFF = '0,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic [SEG_W-1:0]  tgt_seg,
   input  logic [OFF_W-1:0]  tgt_off,
   input  logic              opnd_req,
   input  logic              fetch_ack,
   input  logic [CW-1:0]     fill,
   input  logic              take_ok,
   input  logic              first_byte,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [1:0]        push_n,
   output logic              keep_hi,
   output logic              opnd_grant,
   output qstat_e            qstat
);
   localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);

   logic [SEG_W-1:0]  cs_q;
   logic [OFF_W-1:0]  ip_q;
   logic [ADDR_W-1:0] phys;
   logic              req_q, odd_q, stale_q;
   logic [ADDR_W-1:0] addr_q;
   qstat_e            qs_q;
   logic              issue, accept;

   fbq_phys #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .SHIFT (SHIFT),
      .ADDR_W(ADDR_W)
   ) u_phys (
      .seg (cs_q),
      .off (ip_q),
      .phys(phys)
   );

   assign issue  = !req_q && !opnd_req && !redirect && (fill <= ROOM_MAX);
   assign accept = req_q && fetch_ack && !stale_q && !redirect;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         odd_q   <= 1'b0;
         stale_q <= 1'b0;
         addr_q  <= '0;
         cs_q    <= BOOT_SEG;
         ip_q    <= BOOT_OFF;
         qs_q    <= QS_IDLE;
      end else begin
         if (req_q && fetch_ack) begin
            req_q   <= 1'b0;
            stale_q <= 1'b0;
         end else if (issue) begin
            req_q  <= 1'b1;
            addr_q <= phys & ~(ADDR_W'(1));
            odd_q  <= ip_q[0];
         end

         if (redirect) begin
            cs_q <= tgt_seg;
            ip_q <= tgt_off;
            if (req_q && !fetch_ack)
               stale_q <= 1'b1;
         end else if (issue) begin
            ip_q <= ip_q + (ip_q[0] ? OFF_W'(1) : OFF_W'(2));
         end

         if (redirect)
            qs_q <= QS_FLUSH;
         else if (take_ok)
            qs_q <= first_byte ? QS_FIRST : QS_NEXT;
         else
            qs_q <= QS_IDLE;
      end
   end

   assign fetch_req  = req_q;
   assign fetch_addr = addr_q;
   assign push_n     = accept ? (odd_q ? 2'd1 : 2'd2) : 2'd0;
   assign keep_hi    = odd_q;
   assign opnd_grant = opnd_req && !req_q;
   assign qstat      = qs_q;

   // R2
   issue_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> ($past(fill) <= ROOM_MAX && !$past(opnd_req)));

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

   // R6
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !fetch_addr[0]);

   // R5
   flush_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (qstat == QS_FLUSH));

   // R7
   take_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ok && !redirect) |=> qstat[0]);

endmodule

// File: rtl/fbq_top.sv
module fbq_top
   import fbq_pkg::*;
#(
   parameter int DEPTH  = 6,
   parameter int BYTE_W = 8,
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20,
   parameter logic [SEG_W-1:0] BOOT_SEG = '1,
   parameter logic [OFF_W-1:0] BOOT_OFF = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                redirect,
   input  logic [SEG_W-1:0]    target_seg,
   input  logic [OFF_W-1:0]    target_off,
   output logic                fetch_req,
   output logic [ADDR_W-1:0]   fetch_addr,
   input  logic                fetch_ack,
   input  logic [2*BYTE_W-1:0] fetch_data,
   input  logic                opnd_req,
   output logic                opnd_grant,
   input  logic                byte_take,
   input  logic                byte_first,
   output logic                byte_valid,
   output logic [BYTE_W-1:0]   byte_data,
   output logic [1:0]          qstat
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fbq_top: DEPTH must hold at least one fetched word");
      end
      if (ADDR_W < OFF_W) begin : g_bad_addr
         $error("fbq_top: ADDR_W narrower than the offset");
      end
   endgenerate

   logic [CW-1:0]     fill;
   logic [1:0]        push_n;
   logic              keep_hi, take_ok;
   logic [BYTE_W-1:0] lo_b, hi_b, first_in;
   qstat_e            qs;

   assign lo_b     = fetch_data[BYTE_W-1:0];
   assign hi_b     = fetch_data[2*BYTE_W-1:BYTE_W];
   assign first_in = keep_hi ? hi_b : lo_b;
   assign take_ok  = byte_take && byte_valid && !redirect;

   fbq_ctrl #(
      .DEPTH   (DEPTH),
      .SEG_W   (SEG_W),
      .OFF_W   (OFF_W),
      .SHIFT   (SHIFT),
      .ADDR_W  (ADDR_W),
      .BOOT_SEG(BOOT_SEG),
      .BOOT_OFF(BOOT_OFF)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .redirect  (redirect),
      .tgt_seg   (target_seg),
      .tgt_off   (target_off),
      .opnd_req  (opnd_req),
      .fetch_ack (fetch_ack),
      .fill      (fill),
      .take_ok   (take_ok),
      .first_byte(byte_first),
      .fetch_req (fetch_req),
      .fetch_addr(fetch_addr),
      .push_n    (push_n),
      .keep_hi   (keep_hi),
      .opnd_grant(opnd_grant),
      .qstat     (qs)
   );

   fbq_store #(
      .DEPTH (DEPTH),
      .BYTE_W(BYTE_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (redirect),
      .push_n(push_n),
      .in_b0 (first_in),
      .in_b1 (hi_b),
      .pop   (take_ok),
      .fill  (fill),
      .head  (byte_data)
   );

   assign byte_valid = (fill != '0);
   assign qstat      = qs;

   // R5
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !byte_valid);

   // R8
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_valid && !(fetch_req && fetch_ack)) |=> !byte_valid);

endmodule

// File: tb/fbq_top_test.sv
module fbq_top_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        redirect;
   logic [15:0] target_seg, target_off;
   logic        fetch_req;
   logic [19:0] fetch_addr;
   logic        fetch_ack;
   logic [15:0] fetch_data;
   logic        opnd_req, opnd_grant;
   logic        byte_take, byte_first, byte_valid;
   logic [7:0]  byte_data;
   logic [1:0]  qstat;

   always #2 clk = ~clk;

   fbq_top uut (
      .clk(clk), .rst_n(rst_n), .redirect(redirect),
      .target_seg(target_seg), .target_off(target_off),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_ack(fetch_ack), .fetch_data(fetch_data),
      .opnd_req(opnd_req), .opnd_grant(opnd_grant),
      .byte_take(byte_take), .byte_first(byte_first),
      .byte_valid(byte_valid), .byte_data(byte_data), .qstat(qstat)
   );

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   // reference state
   int          mq[$];
   bit          m_req, m_odd, m_stale, last_red;
   int          m_addr;
   logic [15:0] m_cs, m_ip;
   int          m_qs;
   int          hit_full = 0, stale_seen = 0, odd_seen = 0;

   function automatic logic [7:0] memb(input int a);
      return 8'((a * 37) ^ (a >> 5) ^ 8'h5a);
   endfunction

   function automatic int phys(input logic [15:0] s, input logic [15:0] o);
      return ((int'(s) << 4) + int'(o)) & 32'hFFFFF;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare();
      chk(fetch_req == m_req, "R2 fetch request", fetch_req, m_req);
      if (m_req && fetch_req)
         chk(fetch_addr == m_addr[19:0], "R6 fetch address", fetch_addr, m_addr);
      chk(byte_valid == (mq.size() != 0), last_red ? "R5 flush empties" : "R8 byte valid",
          byte_valid, mq.size() != 0);
      if (byte_valid && mq.size() != 0)
         chk(byte_data == memb(mq[0]), "R3 byte order", byte_data, memb(mq[0]));
      chk(qstat == m_qs[1:0], "R7 status code", qstat, m_qs);
      chk(opnd_grant == (opnd_req && !m_req), "R4 operand grant", opnd_grant,
          opnd_req && !m_req);
   endtask

   task automatic step(input int p_take, input int p_opnd, input int p_red, input int max_lat);
      int  sz;
      bit  red, tk, fb, opr, ack, was_req, issue;
      compare();
      red = ($urandom_range(0, 99) < p_red);
      tk  = ($urandom_range(0, 99) < p_take);
      fb  = ($urandom_range(0, 2) == 0);
      opr = ($urandom_range(0, 99) < p_opnd);
      ack = fetch_req && ($urandom_range(0, max_lat) == 0);
      redirect   = red;
      target_seg = 16'($urandom);
      target_off = 16'($urandom);
      byte_take  = tk;
      byte_first = fb;
      opnd_req   = opr;
      fetch_ack  = ack;
      fetch_data = {memb(int'(fetch_addr) + 1), memb(int'(fetch_addr))};
      // reference update for the coming edge
      sz = mq.size();
      m_qs = red ? 2 : ((tk && sz != 0) ? (fb ? 1 : 3) : 0);
      if (red) mq.delete();
      else begin
         if (tk && sz != 0) void'(mq.pop_front());
         if (m_req && ack && !m_stale) begin
            if (m_odd) mq.push_back(m_addr + 1);
            else begin mq.push_back(m_addr); mq.push_back(m_addr + 1); end
         end
      end
      was_req = m_req;
      issue = !m_req && !opr && !red && (sz <= 4);
      if (m_req && ack) begin m_req = 0; m_stale = 0; end
      else if (issue) begin
         m_req  = 1;
         m_addr = phys(m_cs, m_ip) & ~1;
         m_odd  = m_ip[0];
         if (m_odd) odd_seen++;
      end
      if (red) begin
         if (was_req && !ack) begin m_stale = 1; stale_seen++; end
         m_cs = target_seg;
         m_ip = target_off;
      end else if (issue)
         m_ip = m_ip + (m_ip[0] ? 16'd1 : 16'd2);
      if (mq.size() == 6) hit_full++;
      last_red = red;
      @(negedge clk);
   endtask

   task automatic run(input int n, input int pt, input int po, input int pr, input int ml);
      for (int i = 0; i < n; i++) step(pt, po, pr, ml);
   endtask

   initial begin
      rst_n = 1'b0; redirect = 0; target_seg = 0; target_off = 0;
      fetch_ack = 0; fetch_data = 0; opnd_req = 0; byte_take = 0; byte_first = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(fetch_req == 1'b0, "R11 reset request", fetch_req, 0);
      chk(byte_valid == 1'b0, "R11 reset empty", byte_valid, 0);
      chk(qstat == 2'b00, "R11 reset status", qstat, 0);
      m_req = 0; m_odd = 0; m_stale = 0; last_red = 0;
      m_cs = 16'hFFFF; m_ip = 16'h0000; m_qs = 0; m_addr = 0;
      rst_n = 1'b1;
      step(0, 0, 0, 10);
      chk(fetch_req && fetch_addr == 20'hFFFF0, "R11 boot fetch", fetch_addr, 20'hFFFF0);
      run(300, 100, 0, 0, 0);
      run(120, 0, 0, 0, 1);
      run(300, 20, 10, 2, 3);
      run(400, 70, 30, 6, 4);
      run(1500, 50, 15, 4, 3);
      run(500, 90, 5, 10, 6);
      chk(hit_full > 0, "R1 buffer reached six bytes", hit_full, 1);
      chk(odd_seen > 0, "R9 odd target fetched", odd_seen, 1);
      chk(stale_seen > 0, "R10 in-flight word at redirect", stale_seen, 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog R2 actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule